// File: doc/BRIEF.md
# Sequential Multiply/Divide Peripheral

This block is an arithmetic helper that sits on a small processor's register bus. Software loads operands into a 32-bit accumulator and a 16-bit operand register, then sets a go bit in the control register. The block then computes either a 16×16 unsigned product or a 32÷16 unsigned quotient with remainder. It retires one result bit per clock.

The results are written back in place. The accumulator ends up holding the product or the quotient, and a 16-bit remainder register receives the remainder of a division. The accumulator and the remainder change on every clock while the operation runs, so software that reads them early sees partial values. When the last step is done, the go bit drops by itself and a one-clock completion pulse is raised.

The bus is 16 bits wide and has one enable per byte, so every register can be written one byte at a time or as a whole half.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, every register reads zero: the accumulator halves, the operand register, the remainder register and the control register. `done_o` is low.
- R2: The register map is: address 0 is accumulator bits 15:0, address 1 is accumulator bits 31:16, address 2 is the operand register, address 3 is the remainder, and address 4 is control. A write changes only the bytes whose `bus_be` bit is set, where bit 0 covers data bits 7:0 and bit 1 covers bits 15:8. Any other address reads zero.
- R3: In the control register, bit 0 is the mode (1 = multiply, 0 = divide) and bit 7 is go. The control register takes a write only when `bus_be[0]` is set. Writing go = 1 while idle starts an operation and clears the remainder register. Go reads back as 1 for the whole run. Control bits 15:8 and 6:1 read zero.
- R4: A multiply is finished 16 clocks after the starting write. The accumulator then holds the 32-bit product of its original bits 15:0 and the operand register. The upper accumulator half is loaded with zero before the start.
- R5: After k multiply steps, the accumulator holds ((a mod 2^k)·b) shifted left by 16−k, ORed with a shifted right by k.
- R6: A divide is finished 32 clocks after the starting write. The accumulator then holds the quotient and the remainder register holds the remainder. After k steps, the accumulator holds the dividend shifted left by k, ORed with floor((dividend >> (32−k)) / divisor), and the remainder register holds that top-k value modulo the divisor.
- R7: `done_o` is high for exactly one clock: the clock after the final step. In that same clock the go bit reads 0.
- R8: While an operation runs, writes to the accumulator, the remainder register and the control register have no effect.
- R9: A divide by zero still runs for 32 clocks and ends with the done pulse. Its quotient and remainder are not defined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register select |
| bus_be | input | 2 | Byte enables for the write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the register at `bus_addr` |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The hardest states to reach are the partial results in the middle of a run and bus writes that arrive while a run is in progress. The bench keeps the bus address rotating over both accumulator halves, the remainder and control on every clock of a run. Each partial value is checked against a closed-form formula for step k. In some runs the bench also writes the accumulator and the control register at chosen steps, and the final values show that those writes were dropped.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  // register selects on the bus address
  typedef enum logic [2:0] {
    SEL_ACC_LO = 3'd0,
    SEL_ACC_HI = 3'd1,
    SEL_OPB    = 3'd2,
    SEL_REM    = 3'd3,
    SEL_CTRL   = 3'd4
  } reg_sel_e;

  localparam int CTRL_GO_BIT  = 7;
  localparam int CTRL_MUL_BIT = 0;
endpackage

// File: rtl/mdu_wrdec.sv
module mdu_wrdec
  import mdu_pkg::*;
#(
  parameter  int AW = 3,
  parameter  int NB = 2
) (
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [NB-1:0] bus_be,
  output logic [NB-1:0] we_acc_lo,
  output logic [NB-1:0] we_acc_hi,
  output logic [NB-1:0] we_opb,
  output logic [NB-1:0] we_rem,
  output logic          we_ctrl
);
  function automatic logic [NB-1:0] lanes(input logic hit);
    return hit ? bus_be : '0;
  endfunction

  assign we_acc_lo = lanes(bus_wr && bus_addr == AW'(SEL_ACC_LO));
  assign we_acc_hi = lanes(bus_wr && bus_addr == AW'(SEL_ACC_HI));
  assign we_opb    = lanes(bus_wr && bus_addr == AW'(SEL_OPB));
  assign we_rem    = lanes(bus_wr && bus_addr == AW'(SEL_REM));
  assign we_ctrl   = bus_wr && bus_addr == AW'(SEL_CTRL) && bus_be[0];
endmodule

// File: rtl/mdu_step.sv
module mdu_step #(
  parameter  int OPW = 16,
  localparam int RW  = 2 * OPW
) (
  input  logic           mul_mode,
  input  logic [RW-1:0]  acc,
  input  logic [OPW-1:0] rem,
  input  logic [OPW-1:0] opb,
  output logic [RW-1:0]  acc_nx,
  output logic [OPW-1:0] rem_nx
);
  // one shift-add step: add b into the top half when the low bit is set, then shift right
  function automatic logic [RW-1:0] mul_step(input logic [RW-1:0] a, input logic [OPW-1:0] b);
    logic [OPW:0] sum;
    sum = {1'b0, a[RW-1:OPW]} + (a[0] ? {1'b0, b} : '0);
    return {sum, a[OPW-1:1]};
  endfunction

  // one restoring step: shift the dividend MSB into the partial remainder, subtract if it fits
  function automatic logic [RW+OPW-1:0] div_step(input logic [RW-1:0] a,
                                                 input logic [OPW-1:0] r,
                                                 input logic [OPW-1:0] b);
    logic [OPW:0] trial;
    logic         fits;
    trial = {r, a[RW-1]};
    fits  = trial >= {1'b0, b};
    return {a[RW-2:0], fits, fits ? OPW'(trial - {1'b0, b}) : trial[OPW-1:0]};
  endfunction

  always_comb begin
    if (mul_mode) begin
      acc_nx = mul_step(acc, opb);
      rem_nx = rem;
    end else begin
      {acc_nx, rem_nx} = div_step(acc, rem, opb);
    end
  end
endmodule

// File: rtl/mdu_seq.sv
module mdu_seq #(
  parameter  int OPW  = 16,
  localparam int MULN = OPW,
  localparam int DIVN = 2 * OPW,
  localparam int CW   = $clog2(DIVN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          mul_mode,
  output logic          run,
  output logic          last_step,
  output logic [CW-1:0] cnt,
  output logic          done
);
  assign last_step = run && (cnt == (mul_mode ? CW'(MULN - 1) : CW'(DIVN - 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= last_step;
      if (run) begin
        cnt <= cnt + 1'b1;
        if (last_step) run <= 1'b0;
      end else if (launch) begin
        run <= 1'b1;
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import mdu_pkg::*;
#(
  parameter  int OPW = 16,
  parameter  int AW  = 3,
  localparam int NB  = OPW / 8,
  localparam int RW  = 2 * OPW,
  localparam int CW  = $clog2(RW)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [NB-1:0]  bus_be,
  input  logic [OPW-1:0] bus_wdata,
  output logic [OPW-1:0] bus_rdata,
  output logic           done_o
);
  logic [RW-1:0]  acc, acc_nx;
  logic [OPW-1:0] opb, rem, rem_nx;
  logic           mul_mode;

  // named internal events
  logic [NB-1:0] we_acc_lo, we_acc_hi, we_opb, we_rem;
  logic          we_ctrl, launch, run, last_step;
  logic [CW-1:0] cnt;

  mdu_wrdec #(.AW(AW), .NB(NB)) u_wrdec (
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_be   (bus_be),
    .we_acc_lo(we_acc_lo),
    .we_acc_hi(we_acc_hi),
    .we_opb   (we_opb),
    .we_rem   (we_rem),
    .we_ctrl  (we_ctrl)
  );

  assign launch = we_ctrl && bus_wdata[CTRL_GO_BIT] && !run;

  mdu_seq #(.OPW(OPW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .mul_mode (mul_mode),
    .run      (run),
    .last_step(last_step),
    .cnt      (cnt),
    .done     (done_o)
  );

  mdu_step #(.OPW(OPW)) u_step (
    .mul_mode(mul_mode),
    .acc     (acc),
    .rem     (rem),
    .opb     (opb),
    .acc_nx  (acc_nx),
    .rem_nx  (rem_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      rem      <= '0;
      mul_mode <= 1'b0;
    end else if (run) begin
      acc <= acc_nx;
      rem <= rem_nx;
    end else begin
      for (int i = 0; i < NB; i++) begin
        if (we_acc_lo[i]) acc[8*i +: 8]       <= bus_wdata[8*i +: 8];
        if (we_acc_hi[i]) acc[OPW+8*i +: 8]   <= bus_wdata[8*i +: 8];
        if (we_rem[i])    rem[8*i +: 8]       <= bus_wdata[8*i +: 8];
      end
      if (launch)  rem      <= '0;
      if (we_ctrl) mul_mode <= bus_wdata[CTRL_MUL_BIT];
    end
  end

  // the operand register is not guarded: changing it mid-run is a software error
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opb <= '0;
    end else begin
      for (int i = 0; i < NB; i++)
        if (we_opb[i]) opb[8*i +: 8] <= bus_wdata[8*i +: 8];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(SEL_ACC_LO): bus_rdata = acc[OPW-1:0];
      AW'(SEL_ACC_HI): bus_rdata = acc[RW-1:OPW];
      AW'(SEL_OPB):    bus_rdata = opb;
      AW'(SEL_REM):    bus_rdata = rem;
      AW'(SEL_CTRL): begin
        bus_rdata[CTRL_GO_BIT]  = run;
        bus_rdata[CTRL_MUL_BIT] = mul_mode;
      end
      default:         bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mdu_chk.sv
module mdu_chk #(
  parameter  int OPW = 16,
  localparam int CW  = $clog2(2 * OPW)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run,
  input logic           last_step,
  input logic [CW-1:0]  cnt,
  input logic           done_o,
  input logic           mul_mode,
  input logic           we_ctrl,
  input logic           launch,
  input logic [OPW-1:0] rem
);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_follows_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!run && $past(last_step)));

  p_step_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last_step) |=> (run && cnt == CW'($past(cnt) + 1'b1)));

  p_launch_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (run && cnt == '0 && rem == '0));

  p_mode_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && we_ctrl) |=> (mul_mode == $past(mul_mode)));
endmodule

bind muldiv_unit mdu_chk #(.OPW(OPW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .last_step(last_step),
  .cnt      (cnt),
  .done_o   (done_o),
  .mul_mode (mul_mode),
  .we_ctrl  (we_ctrl),
  .launch   (launch),
  .rem      (rem)
);

// File: tb/muldiv_unit_bench.sv
module muldiv_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [1:0]  bus_be = 2'b00;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        done_o;

  always #10 clk = ~clk;

  muldiv_unit u_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_o(done_o)
  );

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";
  bit    finished = 1'b0;

  // behavioural reference state
  bit [31:0] m_acc = 0, m_opa = 0;
  bit [15:0] m_opb = 0, m_rem = 0, m_div = 0;
  bit        m_mul = 0, m_run = 0, m_done = 0, op_ok = 1;
  bit        ok_lo = 1, ok_hi = 1, ok_rem = 1;
  int        m_k = 0;

  function automatic bit [31:0] mul_partial(bit [15:0] a, bit [15:0] b, int k);
    longint unsigned p;
    p = (longint'(a) & ((64'd1 << k) - 1)) * longint'(b);
    return 32'((p << (16 - k)) | (longint'(a) >> k));
  endfunction

  task automatic div_partial(bit [31:0] d, bit [15:0] b, int k,
                             output bit [31:0] acc, output bit [15:0] r);
    longint unsigned top;
    top = longint'(d) >> (32 - k);
    acc = 32'(((longint'(d) << k) & 64'hFFFF_FFFF) | (top / b));
    r   = 16'(top % b);
  endtask

  function automatic bit [15:0] merge(bit [15:0] old, bit [15:0] d, bit [1:0] be);
    bit [15:0] v = old;
    if (be[0]) v[7:0]  = d[7:0];
    if (be[1]) v[15:8] = d[15:8];
    return v;
  endfunction

  task automatic model_edge(bit wr, bit [2:0] a, bit [1:0] be, bit [15:0] d);
    bit was_run = m_run;
    m_done = 0;
    if (was_run) begin
      m_k++;
      if (op_ok) begin
        if (m_mul) m_acc = mul_partial(m_opa[15:0], m_div, m_k);
        else div_partial(m_opa, m_div, m_k, m_acc, m_rem);
      end
      if (m_k == (m_mul ? 16 : 32)) begin
        m_run  = 0;
        m_done = 1;
      end
    end
    if (wr) begin
      case (a)
        3'd0: if (!was_run) begin m_acc[15:0]  = merge(m_acc[15:0], d, be);  if (be == 2'b11) ok_lo = 1; end
        3'd1: if (!was_run) begin m_acc[31:16] = merge(m_acc[31:16], d, be); if (be == 2'b11) ok_hi = 1; end
        3'd2: m_opb = merge(m_opb, d, be);
        3'd3: if (!was_run) begin m_rem = merge(m_rem, d, be); if (be == 2'b11) ok_rem = 1; end
        3'd4: if (!was_run && be[0]) begin
          m_mul = d[0];
          if (d[7]) begin
            m_run = 1; m_k = 0; m_rem = 0; ok_rem = 1;
            m_opa = m_acc; m_div = m_opb;
            op_ok = ok_lo && ok_hi && (d[0] ? (m_acc[31:16] == 0) : (m_opb != 0));
            if (!op_ok) begin ok_lo = 0; ok_hi = 0; ok_rem = 0; end
          end
        end
        default: ;
      endcase
    end
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    case (bus_addr)
      3'd0: if (ok_lo)  chk(cur_req, "acc_lo", bus_rdata, m_acc[15:0]);
      3'd1: if (ok_hi)  chk(cur_req, "acc_hi", bus_rdata, m_acc[31:16]);
      3'd2: chk(cur_req, "opb", bus_rdata, m_opb);
      3'd3: if (ok_rem) chk(cur_req, "rem", bus_rdata, m_rem);
      3'd4: chk(cur_req, "ctrl", bus_rdata, {8'h00, m_run, 6'b0, m_mul});
      default: chk("R2", "unmapped", bus_rdata, 16'h0);
    endcase
    chk("R7", "done_o", done_o, m_done);
  endtask

  task automatic tick(bit wr, bit [2:0] a, bit [1:0] be, bit [15:0] d);
    bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = d;
    @(posedge clk);
    model_edge(wr, a, be, d);
    @(negedge clk);
    bus_wr = 1'b0;
    compare();
  endtask

  // load operands, start, watch every step, then read the final state
  task automatic run_op(bit mul, bit [31:0] a, bit [15:0] b, string step_tag,
                        string fin_tag, bit busy_writes);
    bit [2:0] rot [4] = '{3'd0, 3'd1, 3'd3, 3'd4};
    cur_req = "R2";
    tick(1, 3'd0, 2'b11, a[15:0]);
    tick(1, 3'd1, 2'b11, a[31:16]);
    tick(1, 3'd2, 2'b11, b);
    cur_req = "R3";
    tick(1, 3'd4, 2'b01, {8'h00, 7'h40, mul});
    for (int c = 0; c < 40 && m_run; c++) begin
      if (busy_writes && c == 3) begin
        cur_req = "R8"; tick(1, 3'd1, 2'b11, 16'hDEAD);
      end else if (busy_writes && c == 6) begin
        cur_req = "R8"; tick(1, 3'd4, 2'b01, {8'h00, 7'h40, ~mul});
      end else if (busy_writes && c == 8) begin
        cur_req = "R8"; tick(1, 3'd3, 2'b11, 16'hBEEF);
      end else begin
        cur_req = step_tag; tick(0, rot[c % 4], 2'b00, 16'h0);
      end
    end
    cur_req = fin_tag;
    tick(0, 3'd0, 2'b00, 16'h0);
    tick(0, 3'd1, 2'b00, 16'h0);
    tick(0, 3'd3, 2'b00, 16'h0);
    tick(0, 3'd4, 2'b00, 16'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    for (int a = 0; a < 5; a++) tick(0, 3'(a), 2'b00, 16'h0);

    cur_req = "R2";
    tick(1, 3'd0, 2'b01, 16'hAA34);
    tick(1, 3'd0, 2'b10, 16'h12BB);
    tick(0, 3'd0, 2'b00, 16'h0);
    tick(1, 3'd1, 2'b11, 16'hCAFE);
    tick(1, 3'd2, 2'b10, 16'h5500);
    tick(0, 3'd2, 2'b00, 16'h0);
    tick(1, 3'd3, 2'b01, 16'h0077);
    tick(0, 3'd3, 2'b00, 16'h0);
    tick(1, 3'd4, 2'b10, 16'h0081);
    tick(0, 3'd4, 2'b00, 16'h0);
    tick(1, 3'd4, 2'b01, 16'h0001);
    tick(0, 3'd4, 2'b00, 16'h0);
    tick(0, 3'd5, 2'b00, 16'h0);
    tick(0, 3'd7, 2'b00, 16'h0);

    run_op(1, 32'h0000_FFFF, 16'hFFFF, "R5", "R4", 0);
    run_op(1, 32'h0000_1234, 16'h5678, "R5", "R4", 0);
    run_op(1, 32'h0000_0000, 16'hABCD, "R5", "R4", 0);
    run_op(1, 32'h0000_FFFF, 16'h0001, "R5", "R4", 0);
    run_op(1, 32'h0000_8001, 16'h8000, "R5", "R8", 1);

    run_op(0, 32'hFFFF_FFFF, 16'hFFFF, "R6", "R6", 0);
    run_op(0, 32'd123456789, 16'd1000, "R6", "R6", 0);
    run_op(0, 32'd5,         16'd7,    "R6", "R6", 0);
    run_op(0, 32'h8000_0000, 16'h0001, "R6", "R6", 0);
    run_op(0, 32'hFFFF_FFFF, 16'h0001, "R6", "R8", 1);

    run_op(0, 32'h1234_5678, 16'h0000, "R9", "R9", 0);
    run_op(0, 32'h0001_0000, 16'h0003, "R6", "R6", 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    finished = 1'b1;
    $finish;
  end
endmodule